// File: doc/BRIEF.md
# Sectored Flash Command Controller

This block models a byte-wide, sectored, electrically erasable memory that sits behind a small command state machine. A CPU-side bus supplies an address, a write byte, a read strobe and a write strobe. A plain store to the array does nothing. A byte changes only after a recognised multi-write unlock sequence. Program and erase operations then run for a fixed number of clock cycles. During that time every read returns a progress status word instead of array data.

The array is an internal synchronous memory that starts fully erased, with every byte at 0xFF. The block can program a single byte, erase one sector, erase the whole chip, and switch into an identifier mode in which reads return a manufacturer code and a device code. The sector count, the sector size, the three busy delays and both identifier codes are parameters. Read data arrives one clock after the read strobe and is qualified by a valid flag.

Top module: `flash_ctrl`

## Requirements
- R1: After reset the array reads 0xFF at every address. A read strobe in cycle t gives `rd_valid` high in cycle t+1 with the read result on `rd_data`, and `rd_valid` is low in every other cycle.
- R2: Any write that is not part of a correct unlock sequence leaves the array unchanged. This includes a lone store and a sequence broken by a wrong address or a wrong byte. Such a write returns the controller to array-read mode.
- R3: Byte program uses four writes: 0xAA to offset 0x555, 0x55 to offset 0x2AA, 0xA0 to offset 0x555, then the target address with its data. The byte stored is the old value ANDed with the written data.
- R4: After the final program write, the operation stays busy for PROG_DELAY+2 cycles. Reads inside that window return status. The first read after the window returns the updated byte.
- R5: A status word has bit 7 equal to the inverse of bit 7 of the byte being programmed, or 0 while erasing. Bit 6 starts at 0 after reset and flips after every status read. Bits 5 to 0 are 0.
- R6: Sector erase uses six writes: 0xAA@0x555, 0x55@0x2AA, 0x80@0x555, 0xAA@0x555, 0x55@0x2AA, then 0x30 to any address inside the sector. Every byte of that sector becomes 0xFF and bytes in other sectors keep their values. Busy lasts ERASE_START+ERASE_DELAY+SECTOR_BYTES cycles.
- R7: Chip erase uses the same five-write prefix followed by 0x10 written to 0x555. Every byte becomes 0xFF. Busy lasts ERASE_START+ERASE_DELAY+total-bytes cycles.
- R8: The writes 0xAA@0x555, 0x55@0x2AA, 0x90@0x555 select identifier mode. In this mode a read at an even address returns MFR_CODE (default 0x01) and a read at an odd address returns DEV_CODE (default 0xA4). A write of 0xF0 to any address, or any write that breaks a sequence, returns to array reads.
- R9: Writes issued while an operation is busy are ignored. They neither advance the command sequence nor touch the array.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | ADDR_W | Byte address |
| bus_wdata | input | 8 | Write byte |
| bus_rd | input | 1 | Read strobe |
| bus_wr | input | 1 | Write strobe |
| rd_data | output | 8 | Read result, valid with rd_valid |
| rd_valid | output | 1 | Read result qualifier, one cycle after bus_rd |

## Verification
The embedded assertions watch properties that hold every cycle:
- the one-cycle read latency;
- that no operation is launched while busy;
- that every busy period closes with an array write;
- that a sector sweep never leaves its target sector;
- that identifier mode is entered only on its command byte.

Other behaviour shows only through the bench's scenarios, which compare every read against a behavioural model on every clock:
- AND-only programming;
- the exact busy length;
- the toggling and inverted status bits;
- a sector erase that leaves neighbouring sectors intact;
- writes that are silently dropped during busy or after a broken sequence.

// File: rtl/flash_pkg.sv
package flash_pkg;
  localparam int CMP_W = 11;

  localparam logic [CMP_W-1:0] ADR_A = 11'h555;
  localparam logic [CMP_W-1:0] ADR_B = 11'h2AA;

  localparam logic [7:0] KEY_A     = 8'hAA;
  localparam logic [7:0] KEY_B     = 8'h55;
  localparam logic [7:0] CMD_PROG  = 8'hA0;
  localparam logic [7:0] CMD_ESET  = 8'h80;
  localparam logic [7:0] CMD_IDENT = 8'h90;
  localparam logic [7:0] CMD_RST   = 8'hF0;
  localparam logic [7:0] CMD_SECT  = 8'h30;
  localparam logic [7:0] CMD_CHIP  = 8'h10;

  typedef enum logic [2:0] {
    SQ_IDLE, SQ_K1, SQ_K2, SQ_PROG, SQ_ESET, SQ_EK1, SQ_EK2
  } seq_t;

  typedef enum logic [1:0] {
    OP_PROG, OP_SECT, OP_CHIP
  } op_t;

  typedef enum logic [2:0] {
    EN_IDLE, EN_PWAIT, EN_PRD, EN_PWR, EN_ESTART, EN_EWAIT, EN_SWEEP
  } eng_t;
endpackage

// File: rtl/flash_array.sv
module flash_array #(
  parameter int DEPTH  = 2048,
  parameter int ADDR_W = 11
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [7:0]        wdata,
  input  logic [ADDR_W-1:0] raddr,
  output logic [7:0]        q
);
  logic [7:0] mem [DEPTH];

  initial begin
    for (int i = 0; i < DEPTH; i++) mem[i] = 8'hFF;
  end

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    q <= mem[raddr];
  end
endmodule

// File: rtl/flash_cmd_seq.sv
module flash_cmd_seq
  import flash_pkg::*;
#(
  parameter int ADDR_W = 11
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        wdata,
  input  logic              busy,
  output logic              start,
  output op_t               op,
  output logic              id_mode
);
  seq_t st;
  logic wr_eff, at_a, at_b;
  logic [CMP_W-1:0] a_low;

  assign a_low  = CMP_W'(addr);
  assign at_a   = (a_low == ADR_A);
  assign at_b   = (a_low == ADR_B);
  assign wr_eff = wr && !busy;

  always_comb begin
    start = 1'b0;
    op    = OP_PROG;
    if (wr_eff && st == SQ_PROG) begin
      start = 1'b1;
    end else if (wr_eff && st == SQ_EK2) begin
      if (wdata == CMD_SECT) begin
        start = 1'b1;
        op    = OP_SECT;
      end else if (wdata == CMD_CHIP && at_a) begin
        start = 1'b1;
        op    = OP_CHIP;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st      <= SQ_IDLE;
      id_mode <= 1'b0;
    end else if (wr_eff) begin
      st <= SQ_IDLE;
      case (st)
        SQ_IDLE: begin
          if (at_a && wdata == KEY_A) st <= SQ_K1;
          else id_mode <= 1'b0;
        end
        SQ_K1: begin
          if (at_b && wdata == KEY_B) st <= SQ_K2;
          else id_mode <= 1'b0;
        end
        SQ_K2: begin
          id_mode <= 1'b0;
          if (at_a) begin
            case (wdata)
              CMD_PROG:  st <= SQ_PROG;
              CMD_ESET:  st <= SQ_ESET;
              CMD_IDENT: id_mode <= 1'b1;
              default:   st <= SQ_IDLE;
            endcase
          end
        end
        SQ_ESET: if (at_a && wdata == KEY_A) st <= SQ_EK1;
        SQ_EK1:  if (at_b && wdata == KEY_B) st <= SQ_EK2;
        default: st <= SQ_IDLE;
      endcase
    end
  end

  // R8
  id_enter_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(id_mode) |-> $past(wr && wdata == CMD_IDENT));
endmodule

// File: rtl/flash_engine.sv
module flash_engine
  import flash_pkg::*;
#(
  parameter int ADDR_W      = 11,
  parameter int SEC_W       = 8,
  parameter int PROG_DELAY  = 1000,
  parameter int ERASE_START = 100,
  parameter int ERASE_DELAY = 1000
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  op_t               op,
  input  logic [ADDR_W-1:0] op_addr,
  input  logic [7:0]        op_data,
  input  logic [7:0]        rd_q,
  output logic              busy,
  output logic              erasing,
  output logic              pbit7,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_we,
  output logic [7:0]        mem_wdata
);
  localparam int MAX_A = (PROG_DELAY > ERASE_START) ? PROG_DELAY : ERASE_START;
  localparam int MAX_D = (MAX_A > ERASE_DELAY) ? MAX_A : ERASE_DELAY;
  localparam int CNT_W = $clog2(MAX_D + 1);
  localparam int TSW   = ADDR_W - SEC_W;

  eng_t st;
  logic [CNT_W-1:0] cnt;
  logic [7:0]       pdata;
  logic             chip;
  logic [TSW-1:0]   tgt_sec;
  logic             last;

  assign pbit7     = pdata[7];
  assign last      = chip ? (&mem_addr) : (&mem_addr[SEC_W-1:0]);
  assign mem_we    = (st == EN_PWR) || (st == EN_SWEEP);
  assign mem_wdata = (st == EN_SWEEP) ? 8'hFF : (rd_q & pdata);

  always_ff @(posedge clk) begin
    if (rst) begin
      st       <= EN_IDLE;
      busy     <= 1'b0;
      erasing  <= 1'b0;
      cnt      <= '0;
      pdata    <= '0;
      chip     <= 1'b0;
      tgt_sec  <= '0;
      mem_addr <= '0;
    end else begin
      case (st)
        EN_IDLE: if (start) begin
          busy    <= 1'b1;
          pdata   <= op_data;
          chip    <= (op == OP_CHIP);
          erasing <= (op != OP_PROG);
          tgt_sec <= op_addr[ADDR_W-1:SEC_W];
          if (op == OP_PROG) begin
            st       <= EN_PWAIT;
            cnt      <= CNT_W'(PROG_DELAY - 1);
            mem_addr <= op_addr;
          end else begin
            st  <= EN_ESTART;
            cnt <= CNT_W'(ERASE_START - 1);
            if (op == OP_CHIP) mem_addr <= '0;
            else mem_addr <= {op_addr[ADDR_W-1:SEC_W], {SEC_W{1'b0}}};
          end
        end
        EN_PWAIT: begin
          if (cnt == '0) st <= EN_PRD;
          else cnt <= cnt - 1'b1;
        end
        EN_PRD: st <= EN_PWR;
        EN_PWR: begin
          st   <= EN_IDLE;
          busy <= 1'b0;
        end
        EN_ESTART: begin
          if (cnt == '0) begin
            st  <= EN_EWAIT;
            cnt <= CNT_W'(ERASE_DELAY - 1);
          end else cnt <= cnt - 1'b1;
        end
        EN_EWAIT: begin
          if (cnt == '0) st <= EN_SWEEP;
          else cnt <= cnt - 1'b1;
        end
        EN_SWEEP: begin
          mem_addr <= mem_addr + 1'b1;
          if (last) begin
            st   <= EN_IDLE;
            busy <= 1'b0;
          end
        end
        default: st <= EN_IDLE;
      endcase
    end
  end

  // R9
  start_idle_chk: assert property (@(posedge clk) disable iff (rst)
    start |-> !busy);

  // R4
  busy_end_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> $past(mem_we));

  // R6
  sweep_region_chk: assert property (@(posedge clk) disable iff (rst)
    (st == EN_SWEEP && !chip) |-> (mem_addr[ADDR_W-1:SEC_W] == tgt_sec));
endmodule

// File: rtl/flash_ctrl.sv
module flash_ctrl
  import flash_pkg::*;
#(
  parameter int         NUM_SECTORS  = 8,
  parameter int         SECTOR_BYTES = 256,
  parameter int         PROG_DELAY   = 1000,
  parameter int         ERASE_START  = 100,
  parameter int         ERASE_DELAY  = 1000,
  parameter logic [7:0] MFR_CODE     = 8'h01,
  parameter logic [7:0] DEV_CODE     = 8'hA4,
  localparam int        TOTAL        = NUM_SECTORS * SECTOR_BYTES,
  localparam int        ADDR_W       = $clog2(TOTAL)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [7:0]        bus_wdata,
  input  logic              bus_rd,
  input  logic              bus_wr,
  output logic [7:0]        rd_data,
  output logic              rd_valid
);
  localparam int SEC_W = $clog2(SECTOR_BYTES);

  logic              start, id_mode, busy, erasing, pbit7, mem_we;
  op_t               op;
  logic [ADDR_W-1:0] eng_addr, raddr;
  logic [7:0]        mem_q, mem_wdata;
  logic              tog, sel_stat, sel_id;
  logic [7:0]        stat_r, id_r;

  flash_cmd_seq #(.ADDR_W(ADDR_W)) u_seq (
    .clk(clk), .rst(rst), .wr(bus_wr), .addr(bus_addr), .wdata(bus_wdata),
    .busy(busy), .start(start), .op(op), .id_mode(id_mode)
  );

  flash_engine #(
    .ADDR_W(ADDR_W), .SEC_W(SEC_W), .PROG_DELAY(PROG_DELAY),
    .ERASE_START(ERASE_START), .ERASE_DELAY(ERASE_DELAY)
  ) u_eng (
    .clk(clk), .rst(rst), .start(start), .op(op), .op_addr(bus_addr),
    .op_data(bus_wdata), .rd_q(mem_q), .busy(busy), .erasing(erasing),
    .pbit7(pbit7), .mem_addr(eng_addr), .mem_we(mem_we), .mem_wdata(mem_wdata)
  );

  assign raddr = busy ? eng_addr : bus_addr;

  flash_array #(.DEPTH(TOTAL), .ADDR_W(ADDR_W)) u_mem (
    .clk(clk), .we(mem_we), .waddr(eng_addr), .wdata(mem_wdata),
    .raddr(raddr), .q(mem_q)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_valid <= 1'b0;
      sel_stat <= 1'b0;
      sel_id   <= 1'b0;
      stat_r   <= '0;
      id_r     <= '0;
      tog      <= 1'b0;
    end else begin
      rd_valid <= bus_rd;
      if (bus_rd) begin
        sel_stat <= busy;
        sel_id   <= id_mode;
        stat_r   <= {(erasing ? 1'b0 : ~pbit7), tog, 6'b0};
        id_r     <= bus_addr[0] ? DEV_CODE : MFR_CODE;
        if (busy) tog <= ~tog;
      end
    end
  end

  assign rd_data = sel_stat ? stat_r : (sel_id ? id_r : mem_q);

  // R1
  rd_lat_chk: assert property (@(posedge clk) disable iff (rst)
    bus_rd |=> rd_valid);

  // R1
  rd_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    !bus_rd |=> !rd_valid);
endmodule

// File: tb/sim_flash_ctrl.sv
`timescale 1ns/1ps
module sim_flash_ctrl;
  localparam int NS = 8, SB = 256, PD = 1000, ES = 100, ED = 1000;
  localparam int TOTAL = NS * SB;
  localparam int AW = 11;

  logic clk = 1'b0, rst = 1'b1;
  logic [AW-1:0] bus_addr = '0;
  logic [7:0] bus_wdata = '0;
  logic bus_rd = 1'b0, bus_wr = 1'b0;
  logic [7:0] rd_data;
  logic rd_valid;

  flash_ctrl u0 (.clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rd(bus_rd), .bus_wr(bus_wr), .rd_data(rd_data), .rd_valid(rd_valid));

  always #2.5 clk = ~clk;

  int checks = 0, failures = 0, cyc = 0;
  string tag = "R1";

  // behavioural reference
  logic [7:0] m_mem [TOTAL];
  bit m_busy = 0, m_id = 0, m_tog = 0, e_valid = 0;
  int m_cnt = 0, m_step = 0, m_kind = 0, m_addr = 0;
  logic [7:0] m_data = 0, e_data = 0;

  initial for (int i = 0; i < TOTAL; i++) m_mem[i] = 8'hFF;

  task automatic launch(int kind, int a, logic [7:0] d);
    m_busy = 1; m_kind = kind; m_addr = a; m_data = d;
    m_cnt = (kind == 0) ? PD + 2 : (kind == 1) ? ES + ED + SB : ES + ED + TOTAL;
  endtask

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (rst) begin
      m_busy = 0; m_id = 0; m_tog = 0; m_step = 0; e_valid = 0;
    end else begin
      bit was_busy;
      int a;
      was_busy = m_busy;
      a = int'(bus_addr);
      e_valid = bus_rd;
      if (bus_rd) begin
        if (was_busy) begin
          e_data = {(m_kind == 0) ? ~m_data[7] : 1'b0, m_tog, 6'b0};
          m_tog = ~m_tog;
        end else if (m_id) e_data = bus_addr[0] ? 8'hA4 : 8'h01;
        else e_data = m_mem[a];
      end
      if (was_busy) begin
        m_cnt--;
        if (m_cnt == 0) begin
          m_busy = 0;
          if (m_kind == 0) m_mem[m_addr] = m_mem[m_addr] & m_data;
          else if (m_kind == 1) begin
            for (int i = 0; i < SB; i++) m_mem[(m_addr / SB) * SB + i] = 8'hFF;
          end else begin
            for (int i = 0; i < TOTAL; i++) m_mem[i] = 8'hFF;
          end
        end
      end
      if (bus_wr && !was_busy) begin
        int s;
        s = m_step;
        m_step = 0;
        if (s == 0) begin
          if (a == 'h555 && bus_wdata == 8'hAA) m_step = 1; else m_id = 0;
        end else if (s == 1) begin
          if (a == 'h2AA && bus_wdata == 8'h55) m_step = 2; else m_id = 0;
        end else if (s == 2) begin
          m_id = 0;
          if (a == 'h555 && bus_wdata == 8'hA0) m_step = 3;
          else if (a == 'h555 && bus_wdata == 8'h80) m_step = 4;
          else if (a == 'h555 && bus_wdata == 8'h90) m_id = 1;
        end else if (s == 3) launch(0, a, bus_wdata);
        else if (s == 4) begin
          if (a == 'h555 && bus_wdata == 8'hAA) m_step = 5;
        end else if (s == 5) begin
          if (a == 'h2AA && bus_wdata == 8'h55) m_step = 6;
        end else if (s == 6) begin
          if (bus_wdata == 8'h30) launch(1, a, 0);
          else if (bus_wdata == 8'h10 && a == 'h555) launch(2, 0, 0);
        end
      end
    end
    if (cyc > 100000) begin
      failures++;
      $display("FAIL watchdog: actual=hung expected=finished");
      finish_run();
    end
  end

  always @(negedge clk) begin
    if (!rst) begin
      checks++;
      if (rd_valid !== e_valid || (e_valid && rd_data !== e_data)) begin
        failures++;
        $display("FAIL %s: actual valid=%0b data=%02h expected valid=%0b data=%02h",
                 tag, rd_valid, rd_data, e_valid, e_data);
      end
    end
  end

  task automatic wr(int a, logic [7:0] d);
    bus_wr = 1; bus_addr = AW'(a); bus_wdata = d;
    @(negedge clk); bus_wr = 0;
  endtask

  task automatic rd(int a);
    bus_rd = 1; bus_addr = AW'(a);
    @(negedge clk); bus_rd = 0;
  endtask

  task automatic unlock();
    wr('h555, 8'hAA); wr('h2AA, 8'h55);
  endtask

  task automatic settle();
    while (m_busy) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R1 reset state and read latency
    tag = "R1"; rd(0); rd(1); rd('h7FF); @(negedge clk);
    // R2 lone store and a broken sequence change nothing
    tag = "R2"; wr(5, 8'h00); rd(5);
    wr('h555, 8'hAA); wr('h123, 8'h55); wr('h555, 8'hA0); wr('h20, 8'h00); rd('h20);
    // R3 / R4 / R5 program with status reads while busy
    tag = "R4"; unlock(); wr('h555, 8'hA0); wr('h10, 8'h5A);
    tag = "R5"; rd('h10); rd('h10); rd('h10);
    tag = "R4"; settle(); rd('h10);
    tag = "R3"; unlock(); wr('h555, 8'hA0); wr('h10, 8'h0F); settle(); rd('h10);
    // R9 writes during busy are dropped
    tag = "R9"; unlock(); wr('h555, 8'hA0); wr('h30, 8'h00);
    unlock(); wr('h555, 8'hA0); wr('h31, 8'h00);
    settle(); wr('h31, 8'h00); rd('h31); rd('h30);
    // R8 identifier mode entry and exits
    tag = "R8"; unlock(); wr('h555, 8'h90); rd(0); rd(1); rd('h22);
    wr('h0, 8'hF0); rd('h10);
    unlock(); wr('h555, 8'h90); rd('h3); wr('h40, 8'h12); rd('h10);
    // R6 sector erase keeps neighbouring sectors
    tag = "R6"; unlock(); wr('h555, 8'hA0); wr('h120, 8'h33); settle();
    unlock(); wr('h555, 8'h80); unlock(); wr('hAB, 8'h30);
    rd('h10); rd('h10); settle(); rd('h10); rd('h30); rd('h120);
    // R7 chip erase
    tag = "R7"; unlock(); wr('h555, 8'h80); unlock(); wr('h555, 8'h10);
    rd('h120); settle(); rd('h120); rd('h7FF);
    repeat (3) @(negedge clk);
    finish_run();
  end
endmodule